// File: doc/BRIEF.md
# Boot Strap Capture and Reset Vector Unit

This unit latches three board-level configuration straps at the moment the hardware reset pin is released. It keeps them as read-only mode bits for boot firmware. It also decides the first instruction fetch address after every reset. A hardware reset always leads to the boot ROM entry at 0xFF0000. A software reset leads either to the boot ROM or straight to address 0x000000, which restarts the program without booting. A skip-boot bit that software programs beforehand makes that choice.

The unit also holds the runtime operating-mode bit. This bit picks how the third serial port works: 0 means a synchronous serial port and 1 means a second SPI. The bit starts from strap 0 and software may rewrite it through a small register write bus. The write is accepted only while the dependent peripherals report idle. A refused write leaves the bit unchanged and sets a sticky error flag.

The hardware reset pin is asserted asynchronously and released through a clock synchronizer. All state sits behind that synchronized reset.

Top module: `boot_strap_vector`

## Requirements
- R1: The strap pins are sampled on the clock edge where the synchronized reset releases, and they appear as modeBits[i] = strapPins[i].
- R2: A strap change after release, including one around a software reset, leaves modeBits unchanged until the next hardware reset.
- R3: While reset is held, vectorValid is 0. On the third rising clock edge after hardRstN rises, vectorValid becomes 1 with resetVector = 0xFF0000.
- R4: When swRstReq is high on an edge with vectorValid = 1, vectorValid is 0 for exactly one cycle and then returns to 1. If the skip-boot bit is 0, resetVector becomes 0xFF0000.
- R5: If the skip-boot bit is 1 at the request, the software reset loads resetVector = 0x000000.
- R6: While vectorValid stays high, resetVector does not change, even when the skip-boot bit is rewritten.
- R7: After a hardware reset, peripheralSel equals strap 0 (0 = synchronous serial port, 1 = second SPI). A write to address 1 with periphBusy = 0 loads busWrData[0] into peripheralSel on that edge.
- R8: A write to address 1 while periphBusy = 1 leaves peripheralSel unchanged and sets opModeErr. opModeErr stays set until a hardware reset.
- R9: A write to address 0 loads the skip-boot bit from busWrData[4]. The skip-boot bit, peripheralSel and opModeErr survive a software reset, and a hardware reset clears the skip-boot bit and opModeErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Hardware reset pin, active low, asynchronous assert |
| swRstReq | input | 1 | Software reset request, one-cycle pulse |
| strapPins | input | 3 | Boot configuration straps |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register write address (0 next-config, 1 op-mode) |
| busWrData | input | 16 | Register write data |
| periphBusy | input | 1 | High while peripherals depending on the op-mode bit are enabled |
| modeBits | output | 3 | Captured straps |
| resetVector | output | 24 | First fetch address |
| vectorValid | output | 1 | resetVector is valid |
| peripheralSel | output | 1 | Runtime op-mode bit |
| opModeErr | output | 1 | Sticky refused-write flag |

## Verification
Random strap patterns are applied at each hardware reset. Strap toggling afterwards separates a capture taken at release from a capture that follows the pins. Soft resets come with the skip-boot bit both clear and set, and the bit is rewritten between resets. This separates the value held at the request from the live value and from the hard-reset vector. Op-mode writes with periphBusy high and low tell an accepted write from a refused one, and show whether the error flag is sticky across soft resets.

// File: rtl/bsv_pkg.sv
package bsv_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadVector;   // load vector register and mark valid
    logic vecBoot;      // 1: boot ROM entry, 0: address zero
    logic clearValid;   // software reset in progress
    logic wrNext;       // write next-config register
    logic wrOpMode;     // accepted op-mode write
    logic flagErr;      // refused op-mode write
    logic loadStrapOp;  // seed op-mode bit from strap
  } bsvStrobe_t;
endpackage

// File: rtl/bsv_ctrl.sv
module bsv_ctrl import bsv_pkg::*; #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SYS_ADDR    = 1,
  parameter int NXT_ADDR    = 0
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              swRstReq,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              periphBusy,
  input  logic              skipBoot,
  output logic              rstSyncN,
  output bsvStrobe_t        strobe
);
  typedef enum logic [1:0] {ST_HOLD, ST_RUN, ST_SOFT} ctrlState_t;

  logic [SYNC_STAGES-1:0] rstSync;
  ctrlState_t state, nextState;
  logic softBoot;
  logic sysHit, nxtHit;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) rstSync <= '0;
    else           rstSync <= {rstSync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rstSyncN = rstSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN) begin
      state    <= ST_HOLD;
      softBoot <= 1'b1;
    end else begin
      state <= nextState;
      if (state == ST_RUN && swRstReq) softBoot <= !skipBoot;
    end
  end

  assign sysHit = busWrEn && (busAddr == ADDR_W'(SYS_ADDR));
  assign nxtHit = busWrEn && (busAddr == ADDR_W'(NXT_ADDR));

  always_comb begin
    strobe          = '0;
    nextState       = state;
    strobe.wrNext   = nxtHit;
    strobe.wrOpMode = sysHit && !periphBusy;
    strobe.flagErr  = sysHit && periphBusy;
    case (state)
      ST_HOLD: begin
        strobe.loadVector  = 1'b1;
        strobe.vecBoot     = 1'b1;
        strobe.loadStrapOp = 1'b1;
        nextState          = ST_RUN;
      end
      ST_RUN: begin
        if (swRstReq) begin
          strobe.clearValid = 1'b1;
          nextState         = ST_SOFT;
        end
      end
      ST_SOFT: begin
        strobe.loadVector = 1'b1;
        strobe.vecBoot    = softBoot;
        nextState         = ST_RUN;
      end
      default: nextState = ST_HOLD;
    endcase
  end
endmodule

// File: rtl/bsv_datapath.sv
module bsv_datapath import bsv_pkg::*; #(
  parameter int STRAP_W     = 3,
  parameter int DATA_W      = 16,
  parameter int VEC_W       = 24,
  parameter int SKIP_BIT    = 4,
  parameter int OPMODE_BIT  = 0,
  parameter int OP_STRAP    = 0,
  parameter logic [VEC_W-1:0] BOOT_VECTOR = 24'hFF0000
) (
  input  logic               clk,
  input  logic               rstSyncN,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic [DATA_W-1:0]  busWrData,
  input  bsvStrobe_t         strobe,
  output logic [STRAP_W-1:0] modeBits,
  output logic               skipBoot,
  output logic               peripheralSel,
  output logic               opModeErr,
  output logic [VEC_W-1:0]   resetVector,
  output logic               vectorValid
);
  logic [STRAP_W-1:0] strapShadow;
  logic unusedData;
  assign unusedData = ^busWrData;

  // Tracks the pins while reset is held, freezes at release
  always_ff @(posedge clk) begin
    if (!rstSyncN) strapShadow <= strapPins;
  end
  assign modeBits = strapShadow;

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN) begin
      skipBoot      <= 1'b0;
      peripheralSel <= 1'b0;
      opModeErr     <= 1'b0;
      resetVector   <= '0;
      vectorValid   <= 1'b0;
    end else begin
      if (strobe.wrNext) skipBoot <= busWrData[SKIP_BIT];
      if (strobe.loadStrapOp)   peripheralSel <= strapShadow[OP_STRAP];
      else if (strobe.wrOpMode) peripheralSel <= busWrData[OPMODE_BIT];
      if (strobe.flagErr) opModeErr <= 1'b1;
      if (strobe.clearValid) vectorValid <= 1'b0;
      else if (strobe.loadVector) begin
        vectorValid <= 1'b1;
        resetVector <= strobe.vecBoot ? BOOT_VECTOR : '0;
      end
    end
  end
endmodule

// File: rtl/boot_strap_vector.sv
module boot_strap_vector import bsv_pkg::*; #(
  parameter int STRAP_W     = 3,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int VEC_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int SYS_ADDR    = 1,
  parameter int NXT_ADDR    = 0,
  parameter int SKIP_BIT    = 4,
  parameter int OPMODE_BIT  = 0,
  parameter logic [VEC_W-1:0] BOOT_VECTOR = 24'hFF0000
) (
  input  logic               clk,
  input  logic               hardRstN,
  input  logic               swRstReq,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               periphBusy,
  output logic [STRAP_W-1:0] modeBits,
  output logic [VEC_W-1:0]   resetVector,
  output logic               vectorValid,
  output logic               peripheralSel,
  output logic               opModeErr
);
  logic       rstSyncN;
  logic       skipBoot;
  bsvStrobe_t strobe;

  bsv_ctrl #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
    .SYS_ADDR(SYS_ADDR), .NXT_ADDR(NXT_ADDR)
  ) u_ctrl (
    .clk(clk), .hardRstN(hardRstN), .swRstReq(swRstReq),
    .busWrEn(busWrEn), .busAddr(busAddr), .periphBusy(periphBusy),
    .skipBoot(skipBoot), .rstSyncN(rstSyncN), .strobe(strobe)
  );

  bsv_datapath #(
    .STRAP_W(STRAP_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .SKIP_BIT(SKIP_BIT), .OPMODE_BIT(OPMODE_BIT), .OP_STRAP(0),
    .BOOT_VECTOR(BOOT_VECTOR)
  ) u_dp (
    .clk(clk), .rstSyncN(rstSyncN), .strapPins(strapPins),
    .busWrData(busWrData), .strobe(strobe), .modeBits(modeBits),
    .skipBoot(skipBoot), .peripheralSel(peripheralSel),
    .opModeErr(opModeErr), .resetVector(resetVector),
    .vectorValid(vectorValid)
  );
endmodule

// File: rtl/bsv_checker.sv
module bsv_checker #(
  parameter int STRAP_W  = 3,
  parameter int ADDR_W   = 4,
  parameter int VEC_W    = 24,
  parameter int SYS_ADDR = 1,
  parameter logic [VEC_W-1:0] BOOT_VECTOR = 24'hFF0000
) (
  input logic               clk,
  input logic               hardRstN,
  input logic               rstSyncN,
  input logic               swRstReq,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               periphBusy,
  input logic [STRAP_W-1:0] modeBits,
  input logic [VEC_W-1:0]   resetVector,
  input logic               vectorValid,
  input logic               peripheralSel,
  input logic               opModeErr
);
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rstSyncN)
    $past(rstSyncN) |-> $stable(modeBits)); // R2

  AST_INVALID_IN_RESET: assert property (@(posedge clk) disable iff (!hardRstN)
    !rstSyncN |-> !vectorValid); // R3

  AST_BOOT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstSyncN)
    $rose(rstSyncN) |=> (vectorValid && resetVector == BOOT_VECTOR)); // R3

  AST_SOFT_DROP: assert property (@(posedge clk) disable iff (!rstSyncN)
    (swRstReq && vectorValid) |=> !vectorValid); // R4

  AST_SOFT_RECOVER: assert property (@(posedge clk) disable iff (!rstSyncN)
    (!vectorValid && $past(vectorValid)) |=> vectorValid); // R4

  AST_VECTOR_STABLE: assert property (@(posedge clk) disable iff (!rstSyncN)
    (vectorValid && $past(vectorValid)) |-> $stable(resetVector)); // R6

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstSyncN)
    (busWrEn && busAddr == ADDR_W'(SYS_ADDR) && periphBusy && $past(rstSyncN))
    |=> ($stable(peripheralSel) && opModeErr)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstSyncN)
    opModeErr |=> opModeErr); // R8
endmodule

bind boot_strap_vector bsv_checker #(
  .STRAP_W(STRAP_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
  .SYS_ADDR(SYS_ADDR), .BOOT_VECTOR(BOOT_VECTOR)
) u_bsv_checker (
  .clk(clk), .hardRstN(hardRstN), .rstSyncN(rstSyncN), .swRstReq(swRstReq),
  .busWrEn(busWrEn), .busAddr(busAddr), .periphBusy(periphBusy),
  .modeBits(modeBits), .resetVector(resetVector), .vectorValid(vectorValid),
  .peripheralSel(peripheralSel), .opModeErr(opModeErr)
);

// File: tb/boot_strap_vector_bench.sv
`timescale 1ns/1ps
module boot_strap_vector_bench;
  logic        clk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        swRstReq = 1'b0;
  logic [2:0]  strapPins = 3'b000;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = 4'd0;
  logic [15:0] busWrData = 16'd0;
  logic        periphBusy = 1'b0;
  logic [2:0]  modeBits;
  logic [23:0] resetVector;
  logic        vectorValid;
  logic        peripheralSel;
  logic        opModeErr;

  int testsRun = 0;
  int testsFailed = 0;

  logic [2:0] expMode;
  logic       expSel, expErr, expSkip;

  always #5 clk = ~clk;

  boot_strap_vector u_boot_strap_vector (
    .clk(clk), .hardRstN(hardRstN), .swRstReq(swRstReq), .strapPins(strapPins),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .periphBusy(periphBusy), .modeBits(modeBits), .resetVector(resetVector),
    .vectorValid(vectorValid), .peripheralSel(peripheralSel), .opModeErr(opModeErr)
  );

  function automatic logic [23:0] softVector(input logic skip);
    return skip ? 24'h000000 : 24'hFF0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkSticky();
    chk("R2 modeBits", 32'(modeBits), 32'(expMode));
    chk("R7 peripheralSel", 32'(peripheralSel), 32'(expSel));
    chk("R8 opModeErr", 32'(opModeErr), 32'(expErr));
  endtask

  task automatic hardReset(input logic [2:0] s);
    @(negedge clk);
    hardRstN = 1'b0;
    #1;
    chk("R3 valid low in reset", 32'(vectorValid), 32'd0);
    strapPins = s;
    repeat (3) @(negedge clk);
    hardRstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 valid low before load", 32'(vectorValid), 32'd0);
    @(negedge clk);
    expMode = s; expSel = s[0]; expErr = 1'b0; expSkip = 1'b0;
    chk("R3 valid after release", 32'(vectorValid), 32'd1);
    chk("R3 boot vector", 32'(resetVector), 32'h00FF0000);
    chk("R1 straps captured", 32'(modeBits), 32'(s));
    chk("R7 op-mode from strap", 32'(peripheralSel), 32'(s[0]));
    chk("R9 error cleared", 32'(opModeErr), 32'd0);
    strapPins = ~s;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d, input logic busy);
    busWrEn = 1'b1; busAddr = a; busWrData = d; periphBusy = busy;
    @(negedge clk);
    busWrEn = 1'b0; periphBusy = 1'b0;
    if (a == 4'd0) expSkip = d[4];
    if (a == 4'd1) begin
      if (busy) expErr = 1'b1;
      else      expSel = d[0];
    end
  endtask

  task automatic softReset();
    logic [23:0] held;
    held = resetVector;
    swRstReq = 1'b1;
    @(negedge clk);
    swRstReq = 1'b0;
    chk("R4 valid drops one cycle", 32'(vectorValid), 32'd0);
    @(negedge clk);
    chk("R4 valid returns", 32'(vectorValid), 32'd1);
    if (expSkip) chk("R5 vector zero", 32'(resetVector), 32'(softVector(expSkip)));
    else         chk("R4 vector boot", 32'(resetVector), 32'(softVector(expSkip)));
    chk("R9 state kept over soft reset", 32'({opModeErr, peripheralSel}), 32'({expErr, expSel}));
    if (held === 24'hx) $display("held unknown");
  endtask

  initial begin
    #1500000;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // Directed corners
    hardReset(3'b101);
    strapPins = 3'b010;
    repeat (2) @(negedge clk);
    chk("R2 strap change ignored", 32'(modeBits), 32'b101);
    busWrite(4'd0, 16'h0010, 1'b0);
    chk("R6 vector stable after cfg write", 32'(resetVector), 32'h00FF0000);
    softReset();
    chk("R5 skip vector", 32'(resetVector), 32'h0);
    busWrite(4'd0, 16'h0000, 1'b0);
    chk("R6 vector held", 32'(resetVector), 32'h0);
    softReset();
    busWrite(4'd1, 16'h0000, 1'b1);
    chk("R8 busy write ignored", 32'(peripheralSel), 32'd1);
    chk("R8 error set", 32'(opModeErr), 32'd1);
    busWrite(4'd1, 16'h0000, 1'b0);
    chk("R7 idle write accepted", 32'(peripheralSel), 32'd0);
    chk("R8 error sticky", 32'(opModeErr), 32'd1);
    softReset();
    checkSticky();
    busWrite(4'd0, 16'h0010, 1'b0);
    hardReset(3'b010);
    softReset();
    chk("R9 skip cleared by hard reset", 32'(resetVector), 32'hFF0000);

    // Random mix
    for (int r = 0; r < 20; r++) begin
      hardReset(3'($urandom));
      for (int k = 0; k < 16; k++) begin
        case ($urandom % 5)
          0: busWrite(4'd0, 16'($urandom), 1'b0);
          1: busWrite(4'd1, 16'($urandom), 1'($urandom));
          2: softReset();
          3: begin strapPins = 3'($urandom); @(negedge clk); end
          default: @(negedge clk);
        endcase
        checkSticky();
      end
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule